// File: doc/BRIEF.md
# Stop Mode Power Controller

This controller sits in the always-on domain of a small microcontroller. It decides which clocks and supplies stay alive when the CPU parks itself in its deepest low-power state. A stop request from the CPU moves it from run to stop. At that moment it captures the debug enable, the two low-voltage-detect enables and the reference-clock keep-alive bit. Those captured values then decide, for the whole stop period, the following:
- whether the debug clock stays on;
- whether the reference clock stays on;
- whether the regulator stays in full regulation or drops to standby.

In stop, the CPU and peripheral clock gates are closed and the pads are held. Three things bring the part back to run: an enabled interrupt, a low-voltage interrupt, or a low-voltage reset. A debug halt request brings it straight into the debug-halted state, but only if debug was enabled when stop began. The low-voltage detector watches a supply-low comparator input and reports through either an interrupt pulse or a fixed-length reset pulse. A select input chooses which. Debug memory-access requests receive a one-cycle status: granted in run or halt, refused with an error in stop or wait.

Top module: `stop_pwr_ctrl`

## Requirements
- R1: One cycle after stop_req is sampled in run, cpu_clk_en and per_clk_en are 0 and io_hold is 1.
- R2: In stop, reg_full equals (dbg_en OR (lvd_en AND lvd_stop_en)) as sampled with stop_req. Changes to these inputs during stop have no effect until the next entry.
- R3: In stop, dbg_clk_en equals dbg_en as sampled with stop_req. In run and in debug halt it is 1.
- R4: In stop, refclk_en is 1 only if refclk_stop_en, lvd_en and lvd_stop_en were all 1 when stop_req was sampled. Otherwise it is 0.
- R5: irq_wake sampled in stop makes cpu_clk_en 1 and io_hold 0 on the next cycle.
- R6: dbg_halt_req sampled in stop enters debug halt (dbg_halted=1, cpu_clk_en=1) on the next cycle, only if dbg_en was latched as 1 at stop entry. Otherwise it is ignored and the part stays in stop. dbg_resume returns from halt to run.
- R7: In run, dbg_halt_req enters debug halt on the next cycle only while dbg_en is 1.
- R8: dbg_mem_req yields, one cycle later, a one-cycle pulse. The pulse is mem_err if the part is in stop or wait_in is 1, and mem_ok otherwise. The two are never 1 together.
- R9: A rising edge of supply_low while the detector is active gives a one-cycle lvd_irq pulse on the next cycle and wakes stop, when lvd_rst_sel=0. The detector is active when lvd_en=1 in run, or when armed at stop entry.
- R10: With lvd_rst_sel=1, the same event drives lvd_rst high for exactly 4 cycles starting next cycle and forces run. stop_req is ignored while lvd_rst is high.
- R11: In stop with the detector not armed at entry, a rising edge of supply_low causes neither lvd_irq, lvd_rst nor a wake.
- R12: After reset the part is in run: all four clock enables and reg_full are 1, and every other output is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Always-on clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| stop_req | input | 1 | CPU stop instruction executed |
| wait_in | input | 1 | CPU is in wait |
| irq_wake | input | 1 | Any enabled interrupt pending |
| dbg_en | input | 1 | Debug mode enable |
| dbg_halt_req | input | 1 | Debug command requesting halt |
| dbg_resume | input | 1 | Debug command leaving halt |
| dbg_mem_req | input | 1 | Debug memory access with status |
| lvd_en | input | 1 | Low-voltage detect enable |
| lvd_stop_en | input | 1 | Low-voltage detect kept in stop |
| lvd_rst_sel | input | 1 | 1: detector resets, 0: interrupts |
| refclk_stop_en | input | 1 | Request reference clock in stop |
| supply_low | input | 1 | Supply comparator below threshold |
| cpu_clk_en | output | 1 | CPU clock gate enable |
| per_clk_en | output | 1 | Peripheral clock gate enable |
| dbg_clk_en | output | 1 | Debug logic clock gate enable |
| refclk_en | output | 1 | Internal reference clock enable |
| reg_full | output | 1 | 1: full regulation, 0: standby |
| io_hold | output | 1 | Hold pad states |
| lvd_irq | output | 1 | Low-voltage interrupt pulse |
| lvd_rst | output | 1 | Low-voltage reset pulse |
| dbg_halted | output | 1 | Debug halt state active |
| mem_ok | output | 1 | Debug memory access granted |
| mem_err | output | 1 | Debug memory access refused |

## Verification
The bench changes dbg_en and both detector enables while the part sits in stop. A design that read them live instead of latching them would open the debug clock or raise the regulator mid-stop. It also sends a halt request in stop after debug was switched on only during stop; a design using the live bit would wrongly enter halt. A supply drop during stop with the detector unarmed must not wake the part, and one with it armed must wake it. Further checks cover the reference clock with the detector off (it must stay off), the reset pulse width, and stop requests during the reset (they must be dropped).

// File: rtl/stop_pwr_pkg.sv
package stop_pwr_pkg;
   typedef enum logic [1:0] {
      ST_RUN  = 2'd0,
      ST_STOP = 2'd1,
      ST_HALT = 2'd2
   } spc_state_t;

   typedef struct packed {
      logic dbg;   // debug clock kept in stop
      logic arm;   // detector armed for stop
      logic rclk;  // reference clock kept in stop
   } spc_cfg_t;
endpackage

// File: rtl/spc_lvd.sv
module spc_lvd #(
   parameter int RST_CYCLES = 4
) (
   input  logic clk,
   input  logic rst_n,
   input  logic supply_low,
   input  logic in_stop,
   input  logic lvd_en,
   input  logic armed,
   input  logic sel_rst,
   output logic irq_evt,
   output logic rst_evt,
   output logic rst_busy,
   output logic lvd_irq,
   output logic lvd_rst
);
   localparam int CW = $clog2(RST_CYCLES + 1);

   initial begin
      assert (RST_CYCLES >= 1) else $error("RST_CYCLES must be at least 1");
   end

   logic          low_q;
   logic [CW-1:0] cnt;
   logic          active, rise;

   assign active   = in_stop ? armed : lvd_en;
   assign rise     = supply_low & ~low_q;
   assign rst_busy = (cnt != '0);
   assign irq_evt  = rise & active & ~sel_rst;
   assign rst_evt  = rise & active & sel_rst & ~rst_busy;
   assign lvd_rst  = rst_busy;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         low_q   <= 1'b0;
         lvd_irq <= 1'b0;
         cnt     <= '0;
      end else begin
         low_q   <= supply_low;
         lvd_irq <= irq_evt;
         if (rst_evt)       cnt <= CW'(RST_CYCLES);
         else if (rst_busy) cnt <= cnt - 1'b1;
      end
   end

   a_r9_irq_single: assert property (@(posedge clk) disable iff (!rst_n)
      lvd_irq |=> !lvd_irq);
   a_r10_irq_vs_rst: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(lvd_rst) |-> !lvd_irq);
endmodule

// File: rtl/spc_fsm.sv
module spc_fsm
   import stop_pwr_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       stop_req,
   input  logic       irq_wake,
   input  logic       dbg_en,
   input  logic       halt_req,
   input  logic       resume,
   input  logic       lvd_en,
   input  logic       lvd_stop_en,
   input  logic       refclk_stop_en,
   input  logic       lvd_irq_evt,
   input  logic       lvd_rst_evt,
   input  logic       lvd_rst_busy,
   output spc_state_t st,
   output spc_cfg_t   cfg
);
   spc_state_t st_nx;
   spc_cfg_t   cfg_nx;
   logic       arm_now;

   assign arm_now = lvd_en & lvd_stop_en;

   always_comb begin
      st_nx  = st;
      cfg_nx = cfg;
      if (lvd_rst_evt || lvd_rst_busy) begin
         st_nx  = ST_RUN;
         cfg_nx = '0;
      end else begin
         case (st)
            ST_RUN: begin
               if (halt_req && dbg_en) begin
                  st_nx = ST_HALT;
               end else if (stop_req) begin
                  st_nx       = ST_STOP;
                  cfg_nx.dbg  = dbg_en;
                  cfg_nx.arm  = arm_now;
                  cfg_nx.rclk = refclk_stop_en & arm_now;
               end
            end
            ST_STOP: begin
               if (halt_req && cfg.dbg)          st_nx = ST_HALT;
               else if (irq_wake || lvd_irq_evt) st_nx = ST_RUN;
            end
            ST_HALT: begin
               if (resume) st_nx = ST_RUN;
            end
            default: st_nx = ST_RUN;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st  <= ST_RUN;
         cfg <= '0;
      end else begin
         st  <= st_nx;
         cfg <= cfg_nx;
      end
   end

   a_r1_enter_stop: assert property (@(posedge clk) disable iff (!rst_n)
      (st == ST_RUN && stop_req && !(halt_req && dbg_en) && !lvd_rst_evt && !lvd_rst_busy)
      |=> st == ST_STOP);
   a_r6_halt_gated: assert property (@(posedge clk) disable iff (!rst_n)
      (st == ST_STOP && halt_req && !cfg.dbg) |=> st != ST_HALT);
   a_r10_force_run: assert property (@(posedge clk) disable iff (!rst_n)
      lvd_rst_busy |=> st == ST_RUN);
endmodule

// File: rtl/spc_gate.sv
module spc_gate
   import stop_pwr_pkg::*;
#(
   parameter bit GATE_REG = 1'b0
) (
   input  logic       clk,
   input  logic       rst_n,
   input  spc_state_t st,
   input  spc_cfg_t   cfg,
   output logic       cpu_clk_en,
   output logic       per_clk_en,
   output logic       dbg_clk_en,
   output logic       refclk_en,
   output logic       reg_full,
   output logic       io_hold,
   output logic       halted
);
   localparam int NG = 7;
   logic [NG-1:0] g_d, g_q;

   always_comb begin
      unique case (st)
         ST_STOP: g_d = {1'b0, 1'b0, cfg.dbg, cfg.rclk, cfg.dbg | cfg.arm, 1'b1, 1'b0};
         ST_HALT: g_d = {1'b1, 1'b1, 1'b1, 1'b1, 1'b1, 1'b0, 1'b1};
         default: g_d = {1'b1, 1'b1, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0};
      endcase
   end

   generate
      if (GATE_REG) begin : g_flop
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) g_q <= 7'b1111100;
            else        g_q <= g_d;
         end
      end else begin : g_comb
         assign g_q = g_d;
      end
   endgenerate

   assign {cpu_clk_en, per_clk_en, dbg_clk_en, refclk_en, reg_full, io_hold, halted} = g_q;

   a_r2_reg_steady: assert property (@(posedge clk) disable iff (!rst_n)
      (io_hold && $past(io_hold)) |-> $stable(reg_full));
   a_r4_rclk_needs_reg: assert property (@(posedge clk) disable iff (!rst_n)
      (io_hold && refclk_en) |-> reg_full);
   a_r1_hold_gates_cpu: assert property (@(posedge clk) disable iff (!rst_n)
      io_hold |-> (!cpu_clk_en && !per_clk_en));
endmodule

// File: rtl/spc_memstat.sv
module spc_memstat
   import stop_pwr_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  spc_state_t st,
   input  logic       wait_in,
   input  logic       mem_req,
   output logic       mem_ok,
   output logic       mem_err
);
   logic blocked;
   assign blocked = (st == ST_STOP) | wait_in;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mem_ok  <= 1'b0;
         mem_err <= 1'b0;
      end else begin
         mem_ok  <= mem_req & ~blocked;
         mem_err <= mem_req & blocked;
      end
   end

   a_r8_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
      !(mem_ok && mem_err));
   a_r8_reply: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req |=> (mem_ok || mem_err));
endmodule

// File: rtl/stop_pwr_ctrl.sv
module stop_pwr_ctrl
   import stop_pwr_pkg::*;
#(
   parameter int RST_CYCLES = 4,
   parameter bit GATE_REG   = 1'b0
) (
   input  logic clk,
   input  logic rst_n,
   input  logic stop_req,
   input  logic wait_in,
   input  logic irq_wake,
   input  logic dbg_en,
   input  logic dbg_halt_req,
   input  logic dbg_resume,
   input  logic dbg_mem_req,
   input  logic lvd_en,
   input  logic lvd_stop_en,
   input  logic lvd_rst_sel,
   input  logic refclk_stop_en,
   input  logic supply_low,
   output logic cpu_clk_en,
   output logic per_clk_en,
   output logic dbg_clk_en,
   output logic refclk_en,
   output logic reg_full,
   output logic io_hold,
   output logic lvd_irq,
   output logic lvd_rst,
   output logic dbg_halted,
   output logic mem_ok,
   output logic mem_err
);
   spc_state_t st;
   spc_cfg_t   cfg;
   logic       irq_evt, rst_evt, rst_busy;

   spc_lvd #(.RST_CYCLES(RST_CYCLES)) u_lvd (
      .clk(clk), .rst_n(rst_n), .supply_low(supply_low),
      .in_stop(st == ST_STOP), .lvd_en(lvd_en), .armed(cfg.arm),
      .sel_rst(lvd_rst_sel), .irq_evt(irq_evt), .rst_evt(rst_evt),
      .rst_busy(rst_busy), .lvd_irq(lvd_irq), .lvd_rst(lvd_rst)
   );

   spc_fsm u_fsm (
      .clk(clk), .rst_n(rst_n), .stop_req(stop_req), .irq_wake(irq_wake),
      .dbg_en(dbg_en), .halt_req(dbg_halt_req), .resume(dbg_resume),
      .lvd_en(lvd_en), .lvd_stop_en(lvd_stop_en), .refclk_stop_en(refclk_stop_en),
      .lvd_irq_evt(irq_evt), .lvd_rst_evt(rst_evt), .lvd_rst_busy(rst_busy),
      .st(st), .cfg(cfg)
   );

   spc_gate #(.GATE_REG(GATE_REG)) u_gate (
      .clk(clk), .rst_n(rst_n), .st(st), .cfg(cfg),
      .cpu_clk_en(cpu_clk_en), .per_clk_en(per_clk_en), .dbg_clk_en(dbg_clk_en),
      .refclk_en(refclk_en), .reg_full(reg_full), .io_hold(io_hold),
      .halted(dbg_halted)
   );

   spc_memstat u_mem (
      .clk(clk), .rst_n(rst_n), .st(st), .wait_in(wait_in),
      .mem_req(dbg_mem_req), .mem_ok(mem_ok), .mem_err(mem_err)
   );

   a_r11_no_wake_unarmed: assert property (@(posedge clk) disable iff (!rst_n)
      (st == ST_STOP && !cfg.arm && !irq_wake && !dbg_halt_req) |=> st == ST_STOP);
endmodule

// File: tb/stop_pwr_ctrl_bench.sv
module stop_pwr_ctrl_bench;
   logic clk = 1'b0, rst_n = 1'b0;
   logic stop_req = 0, wait_in = 0, irq_wake = 0, dbg_en = 0, dbg_halt_req = 0;
   logic dbg_resume = 0, dbg_mem_req = 0, lvd_en = 0, lvd_stop_en = 0;
   logic lvd_rst_sel = 0, refclk_stop_en = 0, supply_low = 0;
   logic cpu_clk_en, per_clk_en, dbg_clk_en, refclk_en, reg_full, io_hold;
   logic lvd_irq, lvd_rst, dbg_halted, mem_ok, mem_err;

   always #2 clk = ~clk;

   stop_pwr_ctrl u_stop_pwr_ctrl (
      .clk(clk), .rst_n(rst_n), .stop_req(stop_req), .wait_in(wait_in),
      .irq_wake(irq_wake), .dbg_en(dbg_en), .dbg_halt_req(dbg_halt_req),
      .dbg_resume(dbg_resume), .dbg_mem_req(dbg_mem_req), .lvd_en(lvd_en),
      .lvd_stop_en(lvd_stop_en), .lvd_rst_sel(lvd_rst_sel),
      .refclk_stop_en(refclk_stop_en), .supply_low(supply_low),
      .cpu_clk_en(cpu_clk_en), .per_clk_en(per_clk_en), .dbg_clk_en(dbg_clk_en),
      .refclk_en(refclk_en), .reg_full(reg_full), .io_hold(io_hold),
      .lvd_irq(lvd_irq), .lvd_rst(lvd_rst), .dbg_halted(dbg_halted),
      .mem_ok(mem_ok), .mem_err(mem_err)
   );

   // observation bits: cpu per dbg rclk reg hold irq rst halt ok err
   localparam logic [10:0] CPU = 11'h400, PER = 11'h200, DBG = 11'h100, RCK = 11'h080;
   localparam logic [10:0] REG = 11'h040, HLD = 11'h020, IRQ = 11'h010, RST = 11'h008;
   localparam logic [10:0] HLT = 11'h004, OK = 11'h002, ERR = 11'h001, ALL = 11'h7FF;

   int checks = 0, errors = 0, cyc = 0;
   bit done = 0;
   int          q_due[$];
   logic [10:0] q_mask[$];
   logic [10:0] q_val[$];
   string       q_req[$];

   logic [10:0] obs;
   assign obs = {cpu_clk_en, per_clk_en, dbg_clk_en, refclk_en, reg_full, io_hold,
                 lvd_irq, lvd_rst, dbg_halted, mem_ok, mem_err};

   always @(posedge clk) cyc <= cyc + 1;

   // monitor: pops expected items as they fall due
   always @(negedge clk) begin
      while (q_due.size() > 0 && q_due[0] == cyc) begin
         checks++;
         if ((obs & q_mask[0]) !== (q_val[0] & q_mask[0])) begin
            errors++;
            $display("FAIL %s cycle %0d: actual %b expected %b (mask %b)",
                     q_req[0], cyc, obs & q_mask[0], q_val[0] & q_mask[0], q_mask[0]);
         end
         void'(q_due.pop_front());
         void'(q_mask.pop_front());
         void'(q_val.pop_front());
         void'(q_req.pop_front());
      end
   end

   task automatic step(int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic expect_at(int d, logic [10:0] m, logic [10:0] v, string r);
      q_due.push_back(cyc + d);
      q_mask.push_back(m);
      q_val.push_back(v);
      q_req.push_back(r);
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1;
         if (q_due.size() != 0) begin
            errors += q_due.size();
            $display("FAIL %s: %0d expected items never compared, actual 0 expected 0",
                     q_req[0], q_due.size());
         end
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   endtask

   initial begin
      #(4 * 150000);
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
   end

   initial begin
      step(3);
      rst_n = 1'b1;
      step(1);
      // R12: reset state
      expect_at(1, ALL, CPU|PER|DBG|RCK|REG, "R12");
      step(2);

      // Stop with everything disabled: R1, R2, R3, R4
      stop_req = 1;
      expect_at(1, CPU|PER|DBG|RCK|REG|HLD|HLT, HLD, "R1");
      step(1); stop_req = 0;
      // R2/R3: enables changed during stop must not matter
      dbg_en = 1; lvd_en = 1; lvd_stop_en = 1; refclk_stop_en = 1;
      expect_at(2, CPU|DBG|RCK|REG|HLD, HLD, "R2");
      step(2);
      // R6: halt request refused, debug was off at entry
      dbg_halt_req = 1;
      expect_at(1, CPU|HLT|HLD, HLD, "R6");
      step(1); dbg_halt_req = 0;
      // R11: detector not armed at entry
      supply_low = 1;
      expect_at(1, CPU|IRQ|RST|HLD, HLD, "R11");
      expect_at(2, CPU|IRQ|RST|HLD, HLD, "R11");
      step(2);
      // R5: interrupt wake
      irq_wake = 1;
      expect_at(1, CPU|PER|HLD, CPU|PER, "R5");
      step(1); irq_wake = 0;

      // Stop with debug only: R3, R4, R8, R6
      lvd_en = 0; lvd_stop_en = 0; supply_low = 0;
      step(1);
      stop_req = 1;
      expect_at(1, CPU|DBG|RCK|REG|HLD, DBG|REG|HLD, "R3");
      step(1); stop_req = 0;
      dbg_mem_req = 1;
      expect_at(1, OK|ERR, ERR, "R8");
      step(1); dbg_mem_req = 0;
      dbg_halt_req = 1;
      expect_at(1, CPU|HLT|HLD, CPU|HLT, "R6");
      step(1); dbg_halt_req = 0;
      dbg_mem_req = 1;
      expect_at(1, OK|ERR, OK, "R8");
      step(1); dbg_mem_req = 0;
      dbg_resume = 1;
      expect_at(1, HLT|CPU, CPU, "R6");
      step(1); dbg_resume = 0;

      // Stop with detector armed: R4, R2, R9
      dbg_en = 0; lvd_en = 1; lvd_stop_en = 1; refclk_stop_en = 1; lvd_rst_sel = 0;
      stop_req = 1;
      expect_at(1, CPU|DBG|RCK|REG|HLD, RCK|REG|HLD, "R4");
      step(1); stop_req = 0;
      supply_low = 1;
      expect_at(1, IRQ|CPU|HLD, IRQ|CPU, "R9");
      expect_at(2, IRQ, 11'h0, "R9");
      step(2);
      supply_low = 0;
      step(1);

      // R7: halt from run needs dbg_en
      dbg_halt_req = 1;
      expect_at(1, HLT, 11'h0, "R7");
      step(1);
      dbg_en = 1;
      expect_at(1, HLT|PER, HLT|PER, "R7");
      step(1); dbg_halt_req = 0;
      dbg_resume = 1;
      step(1); dbg_resume = 0;

      // R8: wait blocks, run grants
      wait_in = 1; dbg_mem_req = 1;
      expect_at(1, OK|ERR, ERR, "R8");
      step(1); wait_in = 0;
      expect_at(1, OK|ERR, OK, "R8");
      step(1); dbg_mem_req = 0;
      expect_at(1, OK|ERR, 11'h0, "R8");
      step(1);

      // R9 in run
      supply_low = 1;
      expect_at(1, IRQ, IRQ, "R9");
      step(1); supply_low = 0;
      step(1);

      // R10: reset pulse from stop, stop requests dropped meanwhile
      dbg_en = 0; lvd_rst_sel = 1;
      stop_req = 1;
      expect_at(1, CPU|HLD, HLD, "R10");
      step(1); stop_req = 0;
      supply_low = 1;
      for (int k = 1; k <= 4; k++) expect_at(k, RST|CPU|HLD, RST|CPU, "R10");
      expect_at(5, RST|CPU|HLD, CPU, "R10");
      step(1);
      stop_req = 1;
      step(2); stop_req = 0;
      step(4);
      supply_low = 0;
      step(2);
      finish_run();
   end
endmodule